// File: doc/BRIEF.md
# Gated Interrupt Status Register Bank

This block is a bank of software-visible interrupt status registers. Nine hardware event lines feed twelve status registers. Each register pairs one of four detection types (level, rising edge, falling edge, both edges) with one of three capture gates:

- always open;
- open while a control bit is 1;
- open while a control bit is 0.

Software reads a register to see which events were captured. It clears bits by writing ones to them. Two control registers hold the gate bits, so that sources nobody is watching can be shut off without losing track of their edges.

A separate 8-bit sticky register latches a whole input word the first time it is nonzero. It keeps that word until software clears it. It is built as a two-state machine:

- `STK_EMPTY`: it loads the input every cycle.
- `STK_HELD`: it keeps its value and only accepts clears.

The transitions are:

- `EMPTY->HELD` when a nonzero word is loaded.
- `HELD->EMPTY` when a clear leaves the value zero.
- `HELD->HELD` otherwise.
- `EMPTY->EMPTY` when the loaded word is zero.

A summary register gives one pending bit per status register, each the OR of that register's bits. The same vector also drives an output port.

Access is through a plain word-addressed port. Writes take effect at the clock edge where `wr_en_i` is high. Reads are combinational.

Top module: `irq_status_bank`

## Requirements
- R1: After reset, every status register, both gate control registers and the sticky register read zero, and `pend_o` is zero.
- R2: The word address map is as follows. Unused read bits are zero, and writes to address 15 have no effect.

  | Address | Register | Read bits |
  |---------|----------|-----------|
  | 0 | high-gate control | [1:0] |
  | 1 | low-gate control | [1:0] |
  | 2 + 3*d + g | status register for detection d and gate g | wide field [7:0], single-bit field [8] |
  | 14 | sticky register | [7:0] |
  | 15 | summary (read only) | [12:0] |

  The codes used in the status address are:
  - detection d: 0 level, 1 rising, 2 falling, 3 both edges;
  - gate g: 0 none, 1 active-high, 2 active-low.
- R3: Writing a 1 to a status or sticky bit clears it at that clock edge. A 0 leaves the bit unchanged.
- R4: A level register sets a bit at each edge where the matching input is 1 and the gate is open.
- R5: A rising-edge register sets a bit when the input is 1 now and was 0 at the previous edge.
- R6: A falling-edge register sets a bit when the input is 0 now and was 1 at the previous edge.
- R7: A both-edge register sets a bit whenever the input differs from its value at the previous edge.
- R8: Registers with gate code 0 capture regardless of the control registers.
- R9: In active-high registers, control address 0 bit 0 gates the 8-bit field and bit 1 gates the 1-bit field. Events are captured only while the bit is 1.
- R10: In active-low registers, control address 1 bit 0 gates the 8-bit field and bit 1 gates the 1-bit field. Events are captured only while the bit is 0.
- R11: Edge history keeps updating while a field is gated off, so opening the gate on a steady input creates no edge.
- R12: When a hardware set and a software clear hit the same bit at the same edge, the bit ends up set.
- R13: The sticky register loads the input while it is zero and holds a nonzero value, ignoring the input, until cleared to zero.
- R14: Summary bit k is the OR of status register k (address 2+k) for k = 0 to 11, and bit 12 is the OR of the sticky register. `pend_o` carries the same vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| addr_i | input | 4 | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Combinational read data |
| evt_i | input | 9 | Event lines: [7:0] wide field, [8] single-bit field |
| stk_i | input | 8 | Sticky register input word |
| pend_o | output | 13 | Per-register pending summary |

## Verification
Every status, sticky and control update lands on the rising clock edge that samples the event or the write strobe. A change is therefore readable from the falling edge that follows. Reads and `pend_o` are combinational from those registers.

The bench drives stimulus at falling edges and lets each edge of stimulus complete. It then adds one idle cycle with steady inputs, which brings its model to a fixed point. Only after that does the monitor read the sixteen addresses and `pend_o` at later falling edges. Because inputs stay steady during readback, the expected values cannot move while they are compared.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;

    typedef enum logic [1:0] {
        DET_LEVEL = 2'd0,
        DET_RISE  = 2'd1,
        DET_FALL  = 2'd2,
        DET_BOTH  = 2'd3
    } det_e;

    typedef enum logic [1:0] {
        GATE_NONE = 2'd0,
        GATE_HIGH = 2'd1,
        GATE_LOW  = 2'd2
    } gate_e;

    typedef enum logic {
        STK_EMPTY = 1'b0,
        STK_HELD  = 1'b1
    } stk_state_e;

    localparam int unsigned N_DET         = 4;
    localparam int unsigned N_GATE        = 3;
    localparam int unsigned N_IRQ_REG     = N_DET * N_GATE;
    localparam int unsigned N_FIELD       = 2;
    localparam int unsigned ADDR_EN_HI    = 0;
    localparam int unsigned ADDR_EN_LO    = 1;
    localparam int unsigned ADDR_IRQ_BASE = 2;
    localparam int unsigned ADDR_STICKY   = ADDR_IRQ_BASE + N_IRQ_REG;
    localparam int unsigned ADDR_SUMMARY  = ADDR_STICKY + 1;
    localparam int unsigned N_PEND        = N_IRQ_REG + 1;

endpackage

// File: rtl/irq_field.sv
module irq_field #(
    parameter int unsigned        W   = 8,
    parameter irqbank_pkg::det_e  DET = irqbank_pkg::DET_LEVEL
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] src_i,
    input  logic         cap_en_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] hit;
    logic [W-1:0] set_bits;
    logic [W-1:0] stat_q;

    if (DET == irqbank_pkg::DET_LEVEL) begin : g_level
        assign hit = src_i;
        // R4 / R12: an open gate with a high input always leaves the bit set
        a_r12_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
            cap_en_i |=> (($past(src_i) & ~stat_o) == '0));
    end else begin : g_edge
        logic [W-1:0] hist_q;
        // history runs regardless of the gate (R11)
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) hist_q <= '0;
            else         hist_q <= src_i;
        end
        if (DET == irqbank_pkg::DET_RISE) begin : g_rise
            assign hit = src_i & ~hist_q;
        end else if (DET == irqbank_pkg::DET_FALL) begin : g_fall
            assign hit = ~src_i & hist_q;
        end else begin : g_both
            assign hit = src_i ^ hist_q;
        end
    end

    assign set_bits = hit & {W{cap_en_i}};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stat_q <= '0;
        else         stat_q <= (stat_q & ~clr_i) | set_bits;
    end

    assign stat_o = stat_q;

    // R9 / R10: a closed gate never sets a new bit
    a_r10_closed_gate_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cap_en_i |=> ((stat_o & ~$past(stat_o)) == '0));

    // R3: bits not written with a one survive the edge
    a_r3_zero_write_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|stat_o) |=> (($past(stat_o & ~clr_i) & ~stat_o) == '0));

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int unsigned         FA_W = 8,
    parameter irqbank_pkg::det_e   DET  = irqbank_pkg::DET_LEVEL,
    parameter irqbank_pkg::gate_e  GATE = irqbank_pkg::GATE_NONE,
    localparam int unsigned        RW   = FA_W + 1
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic [RW-1:0]                   evt_i,
    input  logic [irqbank_pkg::N_FIELD-1:0] en_hi_i,
    input  logic [irqbank_pkg::N_FIELD-1:0] en_lo_i,
    input  logic [RW-1:0]                   clr_i,
    output logic [RW-1:0]                   stat_o
);
    logic [irqbank_pkg::N_FIELD-1:0] gate_open;
    logic                            unused_gate_src;

    assign unused_gate_src = ^{en_hi_i, en_lo_i};

    if (GATE == irqbank_pkg::GATE_NONE) begin : g_open
        assign gate_open = '1;
    end else if (GATE == irqbank_pkg::GATE_HIGH) begin : g_high
        assign gate_open = en_hi_i;
    end else begin : g_low
        assign gate_open = ~en_lo_i;
    end

    irq_field #(.W(FA_W), .DET(DET)) u_wide (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .src_i    (evt_i[FA_W-1:0]),
        .cap_en_i (gate_open[0]),
        .clr_i    (clr_i[FA_W-1:0]),
        .stat_o   (stat_o[FA_W-1:0])
    );

    irq_field #(.W(1), .DET(DET)) u_single (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .src_i    (evt_i[FA_W]),
        .cap_en_i (gate_open[1]),
        .clr_i    (clr_i[FA_W]),
        .stat_o   (stat_o[FA_W])
    );

endmodule

// File: rtl/sticky_field.sv
module sticky_field #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] val_o
);
    import irqbank_pkg::*;

    stk_state_e   state_q, state_d;
    logic [W-1:0] val_q, val_d;

    always_comb begin
        state_d = state_q;
        val_d   = val_q;
        unique case (state_q)
            STK_EMPTY: begin
                val_d   = src_i;
                state_d = (src_i != '0) ? STK_HELD : STK_EMPTY;
            end
            STK_HELD: begin
                val_d   = val_q & ~clr_i;
                state_d = ((val_q & ~clr_i) == '0) ? STK_EMPTY : STK_HELD;
            end
            default: begin
                val_d   = '0;
                state_d = STK_EMPTY;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= STK_EMPTY;
            val_q   <= '0;
        end else begin
            state_q <= state_d;
            val_q   <= val_d;
        end
    end

    assign val_o = val_q;

    // R13: a held value ignores the input when nothing is cleared
    a_r13_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == STK_HELD && clr_i == '0) |=> $stable(val_o));

    // R13: an empty register takes the input word
    a_r13_empty_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == STK_EMPTY) |=> (val_o == $past(src_i)));

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int unsigned FA_W = 8,
    parameter int unsigned DW   = 16,
    parameter int unsigned AW   = 4,
    localparam int unsigned RW  = FA_W + 1,
    localparam int unsigned NP  = irqbank_pkg::N_PEND
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    input  logic [RW-1:0] evt_i,
    input  logic [FA_W-1:0] stk_i,
    output logic [NP-1:0] pend_o
);
    import irqbank_pkg::*;

    logic [N_FIELD-1:0] en_hi_q, en_lo_q;
    logic [RW-1:0]      irq_stat [N_IRQ_REG];
    logic [RW-1:0]      irq_clr  [N_IRQ_REG];
    logic [FA_W-1:0]    stk_clr;
    logic [FA_W-1:0]    stk_val;
    logic [NP-1:0]      pend;
    logic               unused_wdata;

    assign unused_wdata = ^wdata_i;

    // gate control registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_hi_q <= '0;
            en_lo_q <= '0;
        end else if (wr_en_i) begin
            if (addr_i == AW'(ADDR_EN_HI)) en_hi_q <= wdata_i[N_FIELD-1:0];
            if (addr_i == AW'(ADDR_EN_LO)) en_lo_q <= wdata_i[N_FIELD-1:0];
        end
    end

    // one status register per detection/gate pair
    for (genvar k = 0; k < N_IRQ_REG; k++) begin : g_irq
        localparam det_e  K_DET  = det_e'(k / N_GATE);
        localparam gate_e K_GATE = gate_e'(k % N_GATE);

        assign irq_clr[k] = (wr_en_i && addr_i == AW'(ADDR_IRQ_BASE + k))
                            ? wdata_i[RW-1:0] : '0;

        irq_status_reg #(.FA_W(FA_W), .DET(K_DET), .GATE(K_GATE)) u_reg (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .evt_i   (evt_i),
            .en_hi_i (en_hi_q),
            .en_lo_i (en_lo_q),
            .clr_i   (irq_clr[k]),
            .stat_o  (irq_stat[k])
        );

        assign pend[k] = |irq_stat[k];
    end

    assign stk_clr = (wr_en_i && addr_i == AW'(ADDR_STICKY)) ? wdata_i[FA_W-1:0] : '0;

    sticky_field #(.W(FA_W)) u_sticky (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .src_i  (stk_i),
        .clr_i  (stk_clr),
        .val_o  (stk_val)
    );

    assign pend[N_IRQ_REG] = |stk_val;
    assign pend_o          = pend;

    // combinational read mux
    always_comb begin
        rdata_o = '0;
        if (addr_i == AW'(ADDR_EN_HI)) rdata_o[N_FIELD-1:0] = en_hi_q;
        if (addr_i == AW'(ADDR_EN_LO)) rdata_o[N_FIELD-1:0] = en_lo_q;
        for (int k = 0; k < N_IRQ_REG; k++) begin
            if (addr_i == AW'(ADDR_IRQ_BASE + k)) rdata_o[RW-1:0] = irq_stat[k];
        end
        if (addr_i == AW'(ADDR_STICKY))  rdata_o[FA_W-1:0] = stk_val;
        if (addr_i == AW'(ADDR_SUMMARY)) rdata_o[NP-1:0]   = pend;
    end

    // R9: a control write lands at its edge
    a_r9_en_hi_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == AW'(ADDR_EN_HI)) |=> (en_hi_q == $past(wdata_i[N_FIELD-1:0])));

    // R2: upper bits of every read are zero
    a_r2_unused_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i != AW'(ADDR_SUMMARY)) |-> (rdata_o[DW-1:RW] == '0));

    // R14: a pending bit drops only at an edge where a write occurred
    a_r14_pend_drop_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_en_i && (|pend_o[N_IRQ_REG-1:0])) |=> (($past(pend_o[N_IRQ_REG-1:0]) & ~pend_o[N_IRQ_REG-1:0]) == '0));

endmodule

// File: tb/irq_status_bank_tb_top.sv
`timescale 1ns/1ps
module irq_status_bank_tb_top;

    typedef struct {
        logic [3:0]  addr;
        logic [15:0] exp;
        logic [12:0] pend;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        drv_we = 1'b0;
    logic [3:0]  drv_addr = '0;
    logic [15:0] drv_wdata = '0;
    logic [8:0]  drv_evt = '0;
    logic [7:0]  drv_stk = '0;
    logic [3:0]  mon_addr = '0;
    logic        mon_busy = 1'b0;
    logic [3:0]  addr_mux;
    logic [15:0] rdata;
    logic [12:0] pend;

    int n_checks = 0;
    int n_errors = 0;
    item_t q[$];

    // bench model, written from the requirements
    logic [8:0] m_stat [12];
    logic [1:0] m_en_hi = '0, m_en_lo = '0;
    logic [8:0] m_prev = '0;
    logic [7:0] m_stk = '0, m_stk_in = '0;

    always #10 clk = ~clk;

    assign addr_mux = mon_busy ? mon_addr : drv_addr;

    irq_status_bank dut_i (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .wr_en_i (drv_we),
        .addr_i  (addr_mux),
        .wdata_i (drv_wdata),
        .rdata_o (rdata),
        .evt_i   (drv_evt),
        .stk_i   (drv_stk),
        .pend_o  (pend)
    );

    function automatic logic [12:0] model_pend();
        logic [12:0] p;
        for (int g = 0; g < 12; g++) p[g] = |m_stat[g];
        p[12] = |m_stk;
        return p;
    endfunction

    task automatic step(input logic [8:0] evt, input logic [7:0] stk,
                        input logic we, input logic [3:0] a, input logic [15:0] wd);
        logic [8:0] ev, gm, clr;
        @(negedge clk);
        drv_evt = evt; drv_stk = stk; drv_we = we; drv_addr = a; drv_wdata = wd;
        m_stk_in = stk;
        @(posedge clk);
        for (int g = 0; g < 12; g++) begin
            case (g / 3)
                0: ev = evt;               // R4 level
                1: ev = evt & ~m_prev;     // R5 rising
                2: ev = ~evt & m_prev;     // R6 falling
                default: ev = evt ^ m_prev; // R7 both
            endcase
            case (g % 3)
                0: gm = 9'h1FF;                              // R8
                1: gm = {m_en_hi[1], {8{m_en_hi[0]}}};       // R9
                default: gm = {~m_en_lo[1], {8{~m_en_lo[0]}}}; // R10
            endcase
            clr = (we && a == 4'(2 + g)) ? wd[8:0] : 9'h0;
            m_stat[g] = (m_stat[g] & ~clr) | (ev & gm);     // R12 set wins
        end
        if (m_stk == 8'h0) m_stk = stk;                     // R13
        else if (we && a == 4'd14) m_stk = m_stk & ~wd[7:0];
        if (we && a == 4'd0) m_en_hi = wd[1:0];
        if (we && a == 4'd1) m_en_lo = wd[1:0];
        m_prev = evt;
    endtask

    task automatic check_all(input string tag);
        item_t it;
        step(m_prev, m_stk_in, 1'b0, 4'd0, 16'h0);
        for (int a = 0; a < 16; a++) begin
            it.addr = 4'(a);
            it.tag  = tag;
            it.pend = model_pend();
            if (a == 0)       it.exp = {14'h0, m_en_hi};
            else if (a == 1)  it.exp = {14'h0, m_en_lo};
            else if (a < 14)  it.exp = {7'h0, m_stat[a-2]};
            else if (a == 14) it.exp = {8'h0, m_stk};
            else              it.exp = {3'h0, model_pend()};
            q.push_back(it);
        end
        do @(posedge clk); while (q.size() != 0 || mon_busy);
    endtask

    task automatic clear_all();
        for (int a = 2; a < 15; a++) step(m_prev, m_stk_in, 1'b1, 4'(a), 16'hFFFF);
    endtask

    // monitor: pops expected items and compares at falling edges
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (q.size() != 0) begin
                mon_busy = 1'b1;
                it = q.pop_front();
                mon_addr = it.addr;
                #1;
                n_checks++;
                if (rdata !== it.exp) begin
                    n_errors++;
                    $display("FAIL %s addr %0d got %h exp %h", it.tag, it.addr, rdata, it.exp);
                end
                if (it.addr == 4'd15) begin
                    n_checks++;
                    if (pend !== it.pend) begin
                        n_errors++;
                        $display("FAIL %s R14 pend_o got %h exp %h", it.tag, pend, it.pend);
                    end
                end
            end else begin
                mon_busy = 1'b0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        for (int g = 0; g < 12; g++) m_stat[g] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        check_all("R1 reset state");

        // gates at reset: high-gated closed, low-gated open
        step(9'h1FF, 8'h00, 1'b0, 4'd0, 16'h0);
        check_all("R4 R5 R8 R9 R10 events with controls at 0");

        step(9'h000, 8'h00, 1'b0, 4'd0, 16'h0);
        check_all("R6 R7 falling inputs");

        step(9'h000, 8'h00, 1'b1, 4'd5, 16'h0000);
        check_all("R3 zero write keeps bits");

        clear_all();
        check_all("R3 write one clears");

        step(9'h000, 8'h00, 1'b1, 4'd15, 16'hFFFF);
        check_all("R2 summary write ignored");

        // flip gates: high open, low closed
        step(9'h000, 8'h00, 1'b1, 4'd0, 16'h0003);
        step(9'h000, 8'h00, 1'b1, 4'd1, 16'h0003);
        step(9'h0A5, 8'h00, 1'b0, 4'd0, 16'h0);
        step(9'h15A, 8'h00, 1'b0, 4'd0, 16'h0);
        check_all("R9 R10 controls at 1");

        clear_all();
        step(9'h000, 8'h00, 1'b1, 4'd0, 16'h0001);
        step(9'h000, 8'h00, 1'b1, 4'd1, 16'h0002);
        step(9'h133, 8'h00, 1'b0, 4'd0, 16'h0);
        step(9'h022, 8'h00, 1'b0, 4'd0, 16'h0);
        check_all("R9 R10 per-field gate bits");

        // R11: edges while gated, then open on a steady input
        step(9'h000, 8'h00, 1'b1, 4'd0, 16'h0000);
        step(9'h000, 8'h00, 1'b1, 4'd1, 16'h0003);
        clear_all();
        step(9'h0FF, 8'h00, 1'b0, 4'd0, 16'h0);
        step(9'h0FF, 8'h00, 1'b0, 4'd0, 16'h0);
        step(9'h0FF, 8'h00, 1'b1, 4'd0, 16'h0003);
        step(9'h0FF, 8'h00, 1'b1, 4'd1, 16'h0000);
        check_all("R11 no spurious edge on re-enable");

        // R12: level set and clear on the same edge
        clear_all();
        step(9'h001, 8'h00, 1'b0, 4'd0, 16'h0);
        step(9'h001, 8'h00, 1'b1, 4'd2, 16'h01FF);
        check_all("R12 set beats clear");

        // R13 sticky behaviour
        step(9'h000, 8'h3C, 1'b0, 4'd0, 16'h0);
        check_all("R13 sticky loads nonzero word");
        step(9'h000, 8'h81, 1'b0, 4'd0, 16'h0);
        check_all("R13 sticky holds against new input");
        step(9'h000, 8'h81, 1'b1, 4'd14, 16'h000C);
        check_all("R13 R3 sticky partial clear holds");
        step(9'h000, 8'h81, 1'b1, 4'd14, 16'h0030);
        check_all("R13 sticky reloads after full clear");

        clear_all();
        step(9'h100, 8'h00, 1'b0, 4'd0, 16'h0);
        check_all("R14 single-bit field summary");

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule